// File: doc/BRIEF.md
# Capture Input Conditioning Channel

This block sits between an external capture pin and a timer's capture register. The raw pin is first brought into the system clock domain. A synchronous glitch filter then ignores any level that does not persist. Last, an edge prescaler decides which transitions of the cleaned signal become capture events. The timer counter and the capture register are not part of the block. They consume the one-cycle strobe and, if they need it, the filtered level.

A 4-bit filter code sets two things together: how often the synchronized input is sampled, and how many samples in a row must agree before the filtered level follows. Two sample timebases exist. One runs every system (kernel) clock. The other is a slower sampling timebase whose period is `SAMP_RATIO` kernel cycles, further divided by 2, 4, 8, 16 or 32. Both are built as clock-enable pulses on the one system clock. A 2-bit prescaler code turns every 1st, 2nd, 4th or 8th qualifying edge into a strobe. A polarity input chooses whether rising or falling edges qualify.

Top module: `cap_cond_channel`

## Requirements
- R1: The raw input reaches the filter through two synchronizing flops. With filter code 0 and `SAMP_RATIO`=1, a change driven before clock edge k appears on `filtOut` after edge k+2.
- R2: `filtOut` takes a new level only after N consecutive samples all show that level. Any sample that equals the current `filtOut` level clears the run count.
- R3: Filter code 0 samples once per sampling-timebase period (every cycle when `SAMP_RATIO`=1) with N=1.
- R4: Codes 1, 2 and 3 sample every kernel cycle, with N=2, 4 and 8 respectively.
- R5: Codes 4/5 sample at the sampling timebase divided by 2, codes 6/7 divided by 4, and codes 8/9 divided by 8. The even code of each pair uses N=6 and the odd code uses N=8.
- R6: Codes 10, 11 and 12 sample at the sampling timebase divided by 16, with N=5, 6 and 8. Codes 13, 14 and 15 sample divided by 32, with N=5, 6 and 8.
- R7: Prescaler code 0, 1, 2 or 3 emits a strobe on every 1st, 2nd, 4th or 8th qualifying edge.
- R8: While `chanEn` is low the edge count is held at zero and no strobe is issued. Edges counted before a disable do not carry over.
- R9: With `fallEdge`=0 only rising edges of `filtOut` qualify. With `fallEdge`=1 only falling edges qualify.
- R10: `capStrobe` is exactly one cycle wide. It rises in the cycle after the qualifying edge that reaches the terminal count, and the count then wraps to zero.
- R11: A change of the filter code clears the run count and the sample divider. `filtOut` keeps its level until the input requalifies under the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (kernel) clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | 1 | Unsynchronized capture pin |
| fltCode | input | 4 | Filter rate / run-length code |
| pscCode | input | 2 | Edge prescaler code |
| fallEdge | input | 1 | 1 = falling edges qualify, 0 = rising |
| chanEn | input | 1 | Channel enable; low clears the prescaler |
| filtOut | output | 1 | Filtered input level |
| capStrobe | output | 1 | One-cycle capture event |

## Verification
The embedded properties assume that `fltCode` changes only as a deliberate reconfiguration. They also assume that `pscCode` is not lowered while edges are partly counted. The stimulus therefore changes the prescaler code only with the channel disabled, and changes the filter code only while the input is quiet, apart from one directed case that changes it mid-run on purpose. Pulse widths are chosen a whole number of sample periods above or below the run length, so that acceptance or rejection does not depend on the divider phase.

// File: rtl/cap_cond_pkg.sv
package cap_cond_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic       sampleEn;  // take one filter sample this cycle
    logic       restart;   // filter setting changed: clear run state
    logic [3:0] runLen;    // consecutive samples required
  } ctlStrobes_t;

  typedef struct packed {
    logic       kernelRate; // sample every kernel cycle
    logic [2:0] divLog;     // log2 of divider applied to sampling timebase
    logic [3:0] runLen;
  } fltSetting_t;

  function automatic fltSetting_t decodeFlt(input logic [3:0] code);
    fltSetting_t s;
    s = '{kernelRate: 1'b0, divLog: 3'd0, runLen: 4'd1};
    case (code)
      4'd0:  s = '{1'b0, 3'd0, 4'd1};
      4'd1:  s = '{1'b1, 3'd0, 4'd2};
      4'd2:  s = '{1'b1, 3'd0, 4'd4};
      4'd3:  s = '{1'b1, 3'd0, 4'd8};
      4'd4:  s = '{1'b0, 3'd1, 4'd6};
      4'd5:  s = '{1'b0, 3'd1, 4'd8};
      4'd6:  s = '{1'b0, 3'd2, 4'd6};
      4'd7:  s = '{1'b0, 3'd2, 4'd8};
      4'd8:  s = '{1'b0, 3'd3, 4'd6};
      4'd9:  s = '{1'b0, 3'd3, 4'd8};
      4'd10: s = '{1'b0, 3'd4, 4'd5};
      4'd11: s = '{1'b0, 3'd4, 4'd6};
      4'd12: s = '{1'b0, 3'd4, 4'd8};
      4'd13: s = '{1'b0, 3'd5, 4'd5};
      4'd14: s = '{1'b0, 3'd5, 4'd6};
      default: s = '{1'b0, 3'd5, 4'd8};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cap_cond_ctrl.sv
module cap_cond_ctrl
  import cap_cond_pkg::*;
#(
  parameter int SAMP_RATIO = 1,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] fltCode,
  output ctlStrobes_t       strobes
);

  localparam int MAX_DIV = SAMP_RATIO * 32;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  fltSetting_t        setting;
  logic [CODE_W-1:0]  prevCode;
  logic [DIV_W-1:0]   divisor;
  logic [DIV_W-1:0]   divCnt;
  logic               restart;
  logic               tick;

  always_comb begin
    setting = decodeFlt(fltCode);
    if (setting.kernelRate) divisor = DIV_W'(1);
    else                    divisor = DIV_W'(SAMP_RATIO << setting.divLog);
  end

  assign restart = (fltCode != prevCode);
  assign tick    = (divCnt >= divisor - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCode <= '0;
      divCnt   <= '0;
    end else begin
      prevCode <= fltCode;
      if (restart || tick) divCnt <= '0;
      else                 divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign strobes.sampleEn = tick && !restart;
  assign strobes.restart  = restart;
  assign strobes.runLen   = setting.runLen;

  // R4
  kernel_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setting.kernelRate && !restart) |-> strobes.sampleEn);

  // R11
  restart_clears_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (divCnt == '0));

  // R5
  div_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && $stable(fltCode)) |-> (divCnt < divisor));

endmodule

// File: rtl/cap_cond_datapath.sv
module cap_cond_datapath
  import cap_cond_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [PSC_W-1:0] pscCode,
  input  logic             fallEdge,
  input  logic             chanEn,
  input  ctlStrobes_t      strobes,
  output logic             filtOut,
  output logic             capStrobe
);

  localparam int MAX_EDGES = 1 << ((1 << PSC_W) - 1);
  localparam int PCNT_W    = $clog2(MAX_EDGES);

  logic              syncA, syncB;
  logic [3:0]        runCnt;
  logic              filtLevel, prevLevel;
  logic              qualEdge;
  logic [PCNT_W-1:0] pscCnt;
  logic [PCNT_W-1:0] pscTerm;

  // two-flop synchronizer and glitch filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      runCnt    <= '0;
      filtLevel <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (strobes.restart) begin
        runCnt <= '0;
      end else if (strobes.sampleEn) begin
        if (syncB == filtLevel) begin
          runCnt <= '0;
        end else if (runCnt + 4'd1 >= strobes.runLen) begin
          filtLevel <= syncB;
          runCnt    <= '0;
        end else begin
          runCnt <= runCnt + 4'd1;
        end
      end
    end
  end

  // edge qualification and prescaler
  assign qualEdge = fallEdge ? (prevLevel && !filtLevel) : (!prevLevel && filtLevel);
  assign pscTerm  = PCNT_W'((1 << pscCode) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      pscCnt    <= '0;
      capStrobe <= 1'b0;
    end else begin
      prevLevel <= filtLevel;
      capStrobe <= 1'b0;
      if (!chanEn) begin
        pscCnt <= '0;
      end else if (qualEdge) begin
        if (pscCnt >= pscTerm) begin
          pscCnt    <= '0;
          capStrobe <= 1'b1;
        end else begin
          pscCnt <= pscCnt + PCNT_W'(1);
        end
      end
    end
  end

  assign filtOut = filtLevel;

  // R2
  level_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLevel) |-> $past(strobes.sampleEn));

  // R2
  level_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLevel) |-> ($past(syncB) == filtLevel));

  // R10
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> !capStrobe);

  // R8
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (pscCnt == '0 && !capStrobe));

  // R9
  strobe_from_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> ($past(chanEn) && $past(fallEdge ? !filtLevel : filtLevel)));

endmodule

// File: rtl/cap_cond_channel.sv
module cap_cond_channel
  import cap_cond_pkg::*;
#(
  parameter int SAMP_RATIO = 1,
  parameter int CODE_W     = 4,
  parameter int PSC_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [CODE_W-1:0] fltCode,
  input  logic [PSC_W-1:0]  pscCode,
  input  logic              fallEdge,
  input  logic              chanEn,
  output logic              filtOut,
  output logic              capStrobe
);

  ctlStrobes_t strobes;

  cap_cond_ctrl #(
    .SAMP_RATIO(SAMP_RATIO),
    .CODE_W    (CODE_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .fltCode(fltCode),
    .strobes(strobes)
  );

  cap_cond_datapath #(
    .PSC_W(PSC_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    (rawIn),
    .pscCode  (pscCode),
    .fallEdge (fallEdge),
    .chanEn   (chanEn),
    .strobes  (strobes),
    .filtOut  (filtOut),
    .capStrobe(capStrobe)
  );

endmodule

// File: tb/tb_cap_cond_channel.sv
module tb_cap_cond_channel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b0;
  logic [3:0] fltCode = 4'd0;
  logic [1:0] pscCode = 2'd0;
  logic       fallEdge = 1'b0;
  logic       chanEn = 1'b0;
  logic       filtOut, capStrobe;

  int checks = 0;
  int fails = 0;
  int strobeCount = 0;
  logic prevStrobe = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cap_cond_channel dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .fltCode(fltCode),
    .pscCode(pscCode), .fallEdge(fallEdge), .chanEn(chanEn),
    .filtOut(filtOut), .capStrobe(capStrobe)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (capStrobe) strobeCount++;
      if (capStrobe && prevStrobe) begin
        fails++;
        $display("FAIL R10: strobe wider than one cycle, actual 2 expected 1");
      end
      prevStrobe <= capStrobe;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // fields: code[35:32] psc[31:30] pol[29] pulses[28:25] width[24:17] gap[16:9] expStrobes[8:5]
  localparam int NVEC = 14;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0,  2'd0, 1'b0, 4'd5, 8'd4,   8'd40,  4'd5, 5'd0},  // R3 R7 every edge
    {4'd0,  2'd1, 1'b0, 4'd6, 8'd4,   8'd40,  4'd3, 5'd0},  // R7 every 2nd
    {4'd0,  2'd2, 1'b1, 4'd8, 8'd4,   8'd40,  4'd2, 5'd0},  // R7 R9 every 4th, falling
    {4'd0,  2'd3, 1'b0, 4'd8, 8'd4,   8'd40,  4'd1, 5'd0},  // R7 every 8th
    {4'd3,  2'd0, 1'b0, 4'd4, 8'd7,   8'd40,  4'd0, 5'd0},  // R4 N=8 rejects 7
    {4'd3,  2'd0, 1'b0, 4'd4, 8'd8,   8'd40,  4'd4, 5'd0},  // R4 N=8 accepts 8
    {4'd1,  2'd0, 1'b0, 4'd3, 8'd1,   8'd40,  4'd0, 5'd0},  // R4 N=2 rejects 1
    {4'd1,  2'd0, 1'b1, 4'd3, 8'd2,   8'd40,  4'd3, 5'd0},  // R4 R9 N=2 accepts 2
    {4'd4,  2'd0, 1'b0, 4'd3, 8'd10,  8'd60,  4'd0, 5'd0},  // R5 /2 N=6 rejects
    {4'd4,  2'd0, 1'b0, 4'd3, 8'd12,  8'd60,  4'd3, 5'd0},  // R5 /2 N=6 accepts
    {4'd7,  2'd0, 1'b0, 4'd2, 8'd36,  8'd100, 4'd2, 5'd0},  // R5 /4 N=8 accepts
    {4'd10, 2'd0, 1'b0, 4'd2, 8'd64,  8'd200, 4'd0, 5'd0},  // R6 /16 N=5 rejects
    {4'd10, 2'd0, 1'b0, 4'd2, 8'd96,  8'd200, 4'd2, 5'd0},  // R6 /16 N=5 accepts
    {4'd13, 2'd0, 1'b0, 4'd1, 8'd200, 8'd250, 4'd1, 5'd0}   // R6 /32 N=5 accepts
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    // reset state (R1)
    check("R1 reset filtOut", int'(filtOut), 0);
    check("R10 reset capStrobe", int'(capStrobe), 0);
    rstN = 1'b1;
    chanEn = 1'b1;
    waitCycles(5);

    // R1 latency with code 0
    rawIn = 1'b1;
    waitCycles(2);
    check("R1 filtOut before edge k+2", int'(filtOut), 0);
    waitCycles(1);
    check("R1 filtOut after edge k+2", int'(filtOut), 1);
    check("R10 strobe not yet", int'(capStrobe), 0);
    waitCycles(1);
    check("R10 strobe rises", int'(capStrobe), 1);
    waitCycles(1);
    check("R10 strobe falls", int'(capStrobe), 0);
    rawIn = 1'b0;
    waitCycles(10);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [35:0] e;
      e = VEC[v];
      chanEn = 1'b0;
      fltCode = e[35:32];
      pscCode = e[31:30];
      fallEdge = e[29];
      waitCycles(80);
      chanEn = 1'b1;
      waitCycles(2);
      strobeCount = 0;
      for (int p = 0; p < int'(e[28:25]); p++) begin
        rawIn = 1'b1;
        waitCycles(int'(e[24:17]));
        rawIn = 1'b0;
        waitCycles(int'(e[16:9]));
      end
      waitCycles(10);
      check($sformatf("R2 R7 vector %0d strobes", v), strobeCount, int'(e[8:5]));
      check($sformatf("R2 vector %0d final level", v), int'(filtOut), 0);
    end

    // R8: edges before a disable are dropped
    chanEn = 1'b0;
    fltCode = 4'd0;
    pscCode = 2'd2;
    fallEdge = 1'b0;
    waitCycles(20);
    chanEn = 1'b1;
    waitCycles(2);
    strobeCount = 0;
    for (int p = 0; p < 3; p++) begin
      rawIn = 1'b1; waitCycles(4); rawIn = 1'b0; waitCycles(8);
    end
    chanEn = 1'b0;
    waitCycles(2);
    chanEn = 1'b1;
    for (int p = 0; p < 3; p++) begin
      rawIn = 1'b1; waitCycles(4); rawIn = 1'b0; waitCycles(8);
    end
    waitCycles(5);
    check("R8 count cleared by disable", strobeCount, 0);
    // R8: no strobe while disabled
    chanEn = 1'b0;
    pscCode = 2'd0;
    strobeCount = 0;
    for (int p = 0; p < 3; p++) begin
      rawIn = 1'b1; waitCycles(4); rawIn = 1'b0; waitCycles(8);
    end
    check("R8 no strobe while disabled", strobeCount, 0);
    check("R8 filter still runs", int'(filtOut), 0);

    // R11: filter code change restarts the run count
    chanEn = 1'b1;
    fltCode = 4'd3;
    waitCycles(20);
    rawIn = 1'b1;
    waitCycles(6);
    fltCode = 4'd2;
    waitCycles(3);
    check("R11 level held after code change", int'(filtOut), 0);
    waitCycles(2);
    check("R11 level requalified under new code", int'(filtOut), 1);
    rawIn = 1'b0;
    waitCycles(20);
    check("R11 level returns low", int'(filtOut), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule